// File: doc/BRIEF.md
# Overlapped Multichannel ADC Scanner

This block drives an eight-input, 12-bit successive-approximation converter over a four-wire serial link. It keeps conversions back to back. Each new control byte is shifted out while the last bits of the previous result are still coming back. The result is one conversion every 16 serial clocks, or every 15 serial clocks in the fast cadence. Chip select stays low for the whole scan, and the serial clock runs without gaps, so a held sample never waits long enough to droop.

A programmable list of up to eight entries sets the order in which channels are converted. Each entry carries a 3-bit channel number and a single-ended flag. The scan walks the list and wraps back to the first entry. Each finished result leaves the block as a tagged 16-bit word on a valid/ready stream. The stream holds one word. The serial clock is never stalled for the consumer. If a result completes while the held word has not been taken (`smp_valid` high and `smp_ready` low in that cycle), the new result is dropped and a sticky overflow flag is raised. A stop request lets the conversion in flight finish and deliver its result. After that, chip select rises.

Top module: `adc_scan_master`

## Requirements
- R1: After reset `adc_cs_n` is 1, `adc_sclk` is 0, `adc_mosi` is 0, `smp_valid` is 0 and `smp_overflow` is 0.
- R2: Each control byte is sent MSB first. Bit 7 is 1 (start), bits 6:4 are the entry channel, bit 3 is 0, bit 2 is the entry single-ended flag, and bits 1:0 are `pd_mode`. `adc_mosi` changes only while `adc_sclk` is low.
- R3: With `fast_cadence`=0 at scan start, the first start bit is on serial clock 1 after chip select falls, and later start bits follow every 16 serial clocks.
- R4: With `fast_cadence`=1 at scan start, start bits follow every 15 serial clocks.
- R5: Counting the start-bit clock as clock 1, result bit b (11 down to 0) is taken from `adc_miso` at the rising edge of clock 20-b. The converter updates `adc_miso` after falling edges.
- R6: Entries 0 through `list_last` are converted in order, then the scan wraps to entry 0. `list_last`=0 repeats entry 0.
- R7: `smp_data` is {channel[2:0], differential flag (1 when the entry's single-ended flag is 0), result[11:0]}, in bits 15:13, 12 and 11:0.
- R8: While `smp_valid`=1 and `smp_ready`=0, `smp_valid` and `smp_data` hold. A result completing at such a time is dropped and sets `smp_overflow`. `smp_overflow` stays set until the next accepted `scan_start`.
- R9: After `scan_stop`, the conversion in flight completes and its word is delivered. No further start bit is sent. Chip select then rises with `adc_sclk` low.
- R10: During a scan `adc_cs_n` stays low and `adc_sclk` has a constant period of 2*SCLK_HALF system clocks.
- R11: `scan_start` during a scan and `scan_stop` while idle have no effect. `fast_cadence`, `pd_mode`, `list_last` and `chan_list` are sampled only when a scan starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_start | input | 1 | Begin a scan (pulse) |
| scan_stop | input | 1 | Finish the current conversion and end the scan (pulse) |
| fast_cadence | input | 1 | 1 = 15-clock period, 0 = 16-clock period |
| pd_mode | input | 2 | Power-down bits placed in each control byte |
| list_last | input | 3 | Index of the last list entry used |
| chan_list | input | 32 | Entry i in bits 4i+3:4i as {single_ended, channel[2:0]} |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_mosi | output | 1 | Control bits to the converter |
| adc_miso | input | 1 | Result bits from the converter |
| smp_valid | output | 1 | Sample word available |
| smp_ready | input | 1 | Consumer accepts the word |
| smp_data | output | 16 | Tagged sample word |
| smp_overflow | output | 1 | Sticky: a sample was dropped |

## Verification
A behavioural converter model in the bench decodes each control byte and answers with a pseudo-random 12-bit code. The same scheme runs four ways:
- An eight-entry list in the 16-clock cadence exposes channel or flag mix-ups and any error in the overlap of result and control bits.
- A three-entry list in the 15-clock cadence, against a consumer that is ready only one cycle in four, separates a correct wrap from a shifted list and shows that short back-pressure loses nothing.
- A one-entry list, with a start pulse and a cadence change injected mid-scan, checks that the scan ignores both.
- A consumer that never accepts tells a held first word from an overwritten one and confirms that overflow is sticky.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  localparam int CH_W   = 3;
  localparam int RES_W  = 12;
  localparam int ENT_W  = CH_W + 1;
  localparam int WORD_W = CH_W + 1 + RES_W;
  localparam int CTRL_W = 8;
  localparam int CAP_FIRST = 8;   // zero-based clock index where result MSB is taken

  typedef struct packed {
    logic            se;
    logic [CH_W-1:0] ch;
  } entry_t;

  typedef struct packed {
    logic [CH_W-1:0]  ch;
    logic             diff;
    logic [RES_W-1:0] res;
  } word_t;

  function automatic logic [CTRL_W-1:0] make_ctrl(entry_t e, logic [1:0] pd);
    return {1'b1, e.ch, 1'b0, e.se, pd};
  endfunction
endpackage

// File: rtl/adcs_sclk_gen.sv
module adcs_sclk_gen #(
  parameter int SCLK_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(SCLK_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == CNT_TOP);
  assign rise = wrap && !sclk;
  assign fall = wrap && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= !sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  assert_sclk_parks_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);
endmodule

// File: rtl/adcs_seq.sv
module adcs_seq
  import adcs_pkg::*;
#(
  parameter int LIST_N = 8,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scan_start,
  input  logic                    scan_stop,
  input  logic                    fast_cadence,
  input  logic [1:0]              pd_mode,
  input  logic [IDX_W-1:0]        list_last,
  input  logic [LIST_N*ENT_W-1:0] chan_list,
  input  logic                    rise,
  input  logic                    fall,
  input  logic                    sclk,
  input  logic                    cap_active,
  output logic                    run,
  output logic                    cs_n,
  output logic                    mosi,
  output logic                    cap_go,
  output entry_t                  cap_entry,
  output logic                    scan_clr
);
  typedef enum logic {ST_IDLE, ST_RUN} st_t;

  st_t                     state;
  logic [4:0]              f;
  logic                    fast_q, send_q, stop_q;
  logic [1:0]              pd_q;
  logic [IDX_W-1:0]        idx, last_q;
  logic [LIST_N*ENT_W-1:0] list_q;
  entry_t                  ent [LIST_N];
  entry_t                  cur;
  logic [CTRL_W-1:0]       ctrl;
  logic [4:0]              f_last;

  for (genvar g = 0; g < LIST_N; g++) begin : g_unpack
    assign ent[g] = entry_t'(list_q[g*ENT_W +: ENT_W]);
  end

  assign cur       = ent[idx];
  assign ctrl      = make_ctrl(cur, pd_q);
  assign f_last    = fast_q ? 5'd14 : 5'd15;
  assign run       = (state == ST_RUN);
  assign cs_n      = (state == ST_IDLE);
  assign scan_clr  = scan_start && (state == ST_IDLE);
  assign cap_go    = run && rise && send_q && (f == 5'(CAP_FIRST));
  assign cap_entry = cur;
  assign mosi      = run && send_q && (f < 5'd8) && ctrl[3'd7 - f[2:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      f      <= '0;
      fast_q <= 1'b0;
      send_q <= 1'b0;
      stop_q <= 1'b0;
      pd_q   <= '0;
      idx    <= '0;
      last_q <= '0;
      list_q <= '0;
    end else if (state == ST_IDLE) begin
      if (scan_start) begin
        state  <= ST_RUN;
        f      <= '0;
        fast_q <= fast_cadence;
        send_q <= 1'b1;
        stop_q <= 1'b0;
        pd_q   <= pd_mode;
        idx    <= '0;
        last_q <= list_last;
        list_q <= chan_list;
      end
    end else begin
      if (scan_stop) stop_q <= 1'b1;
      if (fall) begin
        if (!send_q && !cap_active) begin
          state <= ST_IDLE;
        end
        if (f == f_last) begin
          f <= '0;
          if (stop_q || scan_stop) begin
            send_q <= 1'b0;
          end else if (send_q) begin
            idx <= (idx == last_q) ? '0 : idx + 1'b1;
          end
        end else begin
          f <= f + 1'b1;
        end
      end
    end
  end

  assert_idx_in_list_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (idx <= last_q));
  assert_idle_clock_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
endmodule

// File: rtl/adcs_capture.sv
module adcs_capture
  import adcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rise,
  input  logic   go,
  input  logic   miso,
  input  entry_t entry,
  output logic   active,
  output logic   done,
  output word_t  word
);
  logic [RES_W-1:0] sh;
  logic [3:0]       cnt;
  entry_t           tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      tag    <= '0;
      active <= 1'b0;
      done   <= 1'b0;
      word   <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        active <= 1'b1;
        cnt    <= 4'd1;
        tag    <= entry;
        sh     <= {{(RES_W-1){1'b0}}, miso};
      end else if (active && rise) begin
        sh <= {sh[RES_W-2:0], miso};
        if (cnt == 4'(RES_W - 1)) begin
          active    <= 1'b0;
          done      <= 1'b1;
          word.ch   <= tag.ch;
          word.diff <= !tag.se;
          word.res  <= {sh[RES_W-2:0], miso};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_no_capture_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !active);
endmodule

// File: rtl/adcs_out_stage.sv
module adcs_out_stage
  import adcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              done,
  input  word_t             word,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] data,
  output logic              overflow
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      data     <= '0;
      overflow <= 1'b0;
    end else begin
      if (clr) overflow <= 1'b0;
      if (done) begin
        if (valid && !ready) begin
          overflow <= 1'b1;
        end else begin
          valid <= 1'b1;
          data  <= word;
        end
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));
  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);
endmodule

// File: rtl/adc_scan_master.sv
module adc_scan_master
  import adcs_pkg::*;
#(
  parameter int SCLK_HALF = 4,
  parameter int LIST_N    = 8,
  localparam int IDX_W    = (LIST_N > 1) ? $clog2(LIST_N) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scan_start,
  input  logic                    scan_stop,
  input  logic                    fast_cadence,
  input  logic [1:0]              pd_mode,
  input  logic [IDX_W-1:0]        list_last,
  input  logic [LIST_N*ENT_W-1:0] chan_list,
  output logic                    adc_sclk,
  output logic                    adc_cs_n,
  output logic                    adc_mosi,
  input  logic                    adc_miso,
  output logic                    smp_valid,
  input  logic                    smp_ready,
  output logic [WORD_W-1:0]       smp_data,
  output logic                    smp_overflow
);
  logic   run, rise, fall, cap_go, cap_active, cap_done, scan_clr;
  entry_t cap_entry;
  word_t  cap_word;

  adcs_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(adc_sclk), .rise(rise), .fall(fall)
  );

  adcs_seq #(.LIST_N(LIST_N), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .scan_start(scan_start), .scan_stop(scan_stop),
    .fast_cadence(fast_cadence), .pd_mode(pd_mode),
    .list_last(list_last), .chan_list(chan_list),
    .rise(rise), .fall(fall), .sclk(adc_sclk), .cap_active(cap_active),
    .run(run), .cs_n(adc_cs_n), .mosi(adc_mosi),
    .cap_go(cap_go), .cap_entry(cap_entry), .scan_clr(scan_clr)
  );

  adcs_capture u_cap (
    .clk(clk), .rst_n(rst_n), .rise(rise), .go(cap_go),
    .miso(adc_miso), .entry(cap_entry),
    .active(cap_active), .done(cap_done), .word(cap_word)
  );

  adcs_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .clr(scan_clr),
    .done(cap_done), .word(cap_word), .ready(smp_ready),
    .valid(smp_valid), .data(smp_data), .overflow(smp_overflow)
  );

  assert_mosi_steady_at_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sclk) |-> $stable(adc_mosi));
endmodule

// File: tb/tb_adc_scan_master.sv
`timescale 1ns/1ps
module tb_adc_scan_master;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_start = 1'b0, scan_stop = 1'b0, fast_cadence = 1'b0;
  logic [1:0]  pd_mode = 2'd0;
  logic [2:0]  list_last = 3'd0;
  logic [31:0] chan_list = '0;
  logic        adc_sclk, adc_cs_n, adc_mosi;
  logic        adc_miso = 1'b0;
  logic        smp_valid, smp_overflow;
  logic        smp_ready = 1'b1;
  logic [15:0] smp_data;

  adc_scan_master #(.SCLK_HALF(HALF), .LIST_N(8)) dut (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_stop(scan_stop),
    .fast_cadence(fast_cadence), .pd_mode(pd_mode), .list_last(list_last),
    .chan_list(chan_list), .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n),
    .adc_mosi(adc_mosi), .adc_miso(adc_miso), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .smp_overflow(smp_overflow)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bench configuration, taken from the requirements
  logic [3:0] cfg_list [8];
  int         cfg_last = 0;
  bit         cfg_fast = 0;
  logic [1:0] cfg_pd = 0;

  // Converter model state
  int          clk_no = 0, ctrl_cnt = 0, e_idx = 0, last_start = 0;
  int          conv_total = 0, starts_total = 0, starts_at_stop = 0;
  int          out_pos = 0, per_err = 0, cs_rises = 0, n_out = 0;
  bit          out_pend = 0, stop_arm = 0, stop_fire = 0;
  logic [7:0]  ctrl_sh = 0;
  logic [11:0] res_cur = 0;
  time         last_rise_t = 0;
  logic [15:0] exp_q [$];

  always @(negedge adc_cs_n) begin
    clk_no = 0; ctrl_cnt = 0; e_idx = 0; last_start = 0; out_pend = 0;
  end
  always @(posedge adc_cs_n) cs_rises++;

  always @(posedge adc_sclk) begin
    if (!adc_cs_n) begin
      clk_no++;
      if (clk_no > 1 && ($time - last_rise_t) != 2*HALF*8) per_err++;
      last_rise_t = $time;
      if (ctrl_cnt == 0) begin
        if (adc_mosi) begin
          starts_total++;
          if (last_start == 0)
            chk(clk_no == 1, "R3", "first start clock", clk_no, 1);
          else if (cfg_fast)
            chk(clk_no - last_start == 15, "R4", "start spacing", clk_no - last_start, 15);
          else
            chk(clk_no - last_start == 16, "R3", "start spacing", clk_no - last_start, 16);
          last_start = clk_no;
          ctrl_sh = 8'd1; ctrl_cnt = 1;
          if (stop_arm) begin stop_arm = 0; stop_fire = 1; starts_at_stop = starts_total; end
        end
      end else begin
        ctrl_sh = {ctrl_sh[6:0], adc_mosi};
        ctrl_cnt++;
        if (ctrl_cnt == 8) begin
          logic [7:0] ec;
          ctrl_cnt = 0;
          ec = {1'b1, cfg_list[e_idx][2:0], 1'b0, cfg_list[e_idx][3], cfg_pd};
          chk(ctrl_sh == ec, "R2/R6", "control byte", ctrl_sh, ec);
          res_cur = 12'((conv_total * 1237 + 611) % 4096);
          exp_q.push_back({cfg_list[e_idx][2:0], ~cfg_list[e_idx][3], res_cur});
          e_idx = (e_idx == cfg_last) ? 0 : e_idx + 1;
          conv_total++;
          out_pend = 1; out_pos = 0;
        end
      end
    end
  end

  always @(negedge adc_sclk) begin
    if (!adc_cs_n && out_pend) begin
      adc_miso <= res_cur[11 - out_pos];
      out_pos++;
      if (out_pos == 12) out_pend = 0;
    end else begin
      adc_miso <= 1'b0;
    end
  end

  // Scoreboard monitor (R5, R7)
  always @(negedge clk) begin
    if (rst_n && smp_valid && smp_ready) begin
      n_out++;
      if (exp_q.size() == 0) chk(0, "R7", "unexpected sample", smp_data, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(smp_data == e, "R5/R7", "sample word", smp_data, e);
      end
    end
  end

  // Consumer: 0 = always ready, 1 = ready one cycle in four, 2 = never ready
  int rdy_mode = 0;
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      ph++;
      smp_ready = (rdy_mode == 0) || (rdy_mode == 1 && (ph % 4) == 0);
    end
  end

  task automatic set_list(input logic [3:0] l [8]);
    for (int i = 0; i < 8; i++) begin
      cfg_list[i] = l[i];
      chan_list[4*i +: 4] = l[i];
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 scan_start = 1'b1;
    @(posedge clk); #1 scan_start = 1'b0;
  endtask

  task automatic stop_after_start();
    stop_arm = 1;
    wait (stop_fire);
    stop_fire = 0;
    @(posedge clk); #1 scan_stop = 1'b1;
    @(posedge clk); #1 scan_stop = 1'b0;
    wait (adc_cs_n == 1'b1);
    repeat (10) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_scan(input bit fast, input int last, input logic [1:0] pd,
                          input int nconv, input bit midstart);
    int c0, o0, r0;
    cfg_fast = fast; cfg_last = last; cfg_pd = pd;
    fast_cadence = fast; list_last = 3'(last); pd_mode = pd; per_err = 0;
    c0 = conv_total; o0 = n_out; r0 = cs_rises;
    pulse_start();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(adc_cs_n == 1'b0, "R10", "cs low after start", adc_cs_n, 0);
    if (midstart) begin
      wait (conv_total >= c0 + 3);
      @(posedge clk); #1 fast_cadence = ~fast; scan_start = 1'b1;
      @(posedge clk); #1 scan_start = 1'b0;
      @(negedge clk);
      chk(adc_cs_n == 1'b0, "R11", "start during scan ignored", adc_cs_n, 0);
    end
    wait (conv_total >= c0 + nconv);
    stop_after_start();
    chk(starts_total == starts_at_stop, "R9", "no start after stop", starts_total, starts_at_stop);
    chk(exp_q.size() == 0, "R9", "all results delivered", exp_q.size(), 0);
    chk(n_out - o0 == conv_total - c0, "R9", "word count", n_out - o0, conv_total - c0);
    chk(adc_sclk == 1'b0, "R9", "sclk low after stop", adc_sclk, 0);
    chk(cs_rises - r0 == 1, "R10", "single cs rise per scan", cs_rises - r0, 1);
    chk(per_err == 0, "R10", "sclk period errors", per_err, 0);
    chk(smp_overflow == 1'b0, "R8", "no overflow", smp_overflow, 0);
  endtask

  initial begin
    logic [3:0] la [8];
    #1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(adc_cs_n == 1, "R1", "reset cs_n", adc_cs_n, 1);
    chk(adc_sclk == 0, "R1", "reset sclk", adc_sclk, 0);
    chk(adc_mosi == 0, "R1", "reset mosi", adc_mosi, 0);
    chk(smp_valid == 0 && smp_overflow == 0, "R1", "reset valid/overflow",
        {smp_valid, smp_overflow}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // Stop while idle has no effect (R11)
    @(posedge clk); #1 scan_stop = 1'b1;
    @(posedge clk); #1 scan_stop = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(adc_cs_n == 1 && adc_sclk == 0, "R11", "stop while idle", {adc_cs_n, adc_sclk}, 2);

    // Scan A: eight entries, 16-clock cadence
    la = '{4'hF, 4'h1, 4'hA, 4'h3, 4'hC, 4'h5, 4'h6, 4'hE};
    set_list(la);
    rdy_mode = 0;
    run_scan(1'b0, 7, 2'b11, 20, 1'b0);

    // Scan B: three entries wrapping, 15-clock cadence, slow consumer (R4, R6, R8)
    la = '{4'h2, 4'hD, 4'h0, 4'h7, 4'h7, 4'h7, 4'h7, 4'h7};
    set_list(la);
    rdy_mode = 1;
    run_scan(1'b1, 2, 2'b00, 14, 1'b0);

    // Scan C: one entry repeated, start and cadence change mid-scan ignored (R6, R11)
    la = '{4'h9, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0};
    set_list(la);
    rdy_mode = 0;
    run_scan(1'b0, 0, 2'b01, 8, 1'b1);

    // Overflow: consumer never ready (R8)
    begin
      int c0;
      logic [15:0] first;
      la = '{4'h4, 4'hB, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0};
      set_list(la);
      cfg_fast = 0; cfg_last = 1; cfg_pd = 2'b10;
      fast_cadence = 0; list_last = 3'd1; pd_mode = 2'b10;
      rdy_mode = 2;
      c0 = conv_total;
      pulse_start();
      wait (conv_total >= c0 + 4);
      repeat (4) @(posedge clk);
      @(negedge clk);
      first = exp_q[0];
      chk(smp_valid == 1, "R8", "held word valid", smp_valid, 1);
      chk(smp_data == first, "R8", "first word kept", smp_data, first);
      chk(smp_overflow == 1, "R8", "overflow set", smp_overflow, 1);
      stop_after_start();
      chk(smp_overflow == 1, "R8", "overflow sticky after stop", smp_overflow, 1);
      rdy_mode = 0;
      repeat (4) @(posedge clk);
      exp_q.delete();
      pulse_start();
      @(negedge clk);
      chk(smp_overflow == 0, "R8", "overflow cleared by start", smp_overflow, 0);
      stop_after_start();
      exp_q.delete();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule